// File: doc/BRIEF.md
# Occupancy-Ranked Dual Fetch Selector

This block picks which hardware threads may fetch in the coming cycle of a simultaneous multithreaded front end. For every thread it keeps a live tally of that thread's instructions currently sitting in the stages ahead of execution. Fetching adds to the tally. Issuing and squashing both take from it.

Each cycle the selector looks at the tallies of the threads that are allowed to fetch. It grants the thread with the smallest tally and the thread with the next smallest tally. Fetch bandwidth therefore flows to the threads that are draining their instructions fastest. Each grant is a thread ID with a valid bit.

The grants are combinational from the registered tallies and the current eligibility mask. The tallies update on the rising clock edge.

Top module: `fetch_chooser`

## Requirements
- R1: A synchronous active-high reset sets every thread's occupancy count to zero.
- R2: On each clock edge outside reset, a thread's count becomes its old count plus its fetch delta, minus its issue delta, minus its flush delta. All three deltas are applied in the same cycle.
- R3: When the combined result would go below zero, the count becomes zero.
- R4: When the combined result would exceed 2^CNT_W-1, the count becomes 2^CNT_W-1.
- R5: The first grant names the eligible thread with the smallest count. Among equal counts, the lowest thread ID wins.
- R6: The second grant names the eligible thread with the smallest count once the first-granted thread is removed. Among equal counts, the lowest thread ID wins.
- R7: A thread whose eligibility bit is 0 is never granted. With no eligible thread, neither grant is valid. With exactly one eligible thread, only the first grant is valid.
- R8: A thread whose three deltas are all zero keeps its count unchanged.
- R9: When both grants are valid, they name different threads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eligible | input | N | Bit i set: thread i may fetch this cycle |
| fetch_n | input | N*DELTA_W | Instructions fetched per thread; thread i at bits [i*DELTA_W +: DELTA_W] |
| issue_n | input | N*DELTA_W | Instructions issued per thread, same packing |
| flush_n | input | N*DELTA_W | Pre-execution instructions squashed per thread, same packing |
| grant0_valid | output | 1 | First grant present |
| grant0_id | output | IDW | Thread of the first grant |
| grant1_valid | output | 1 | Second grant present |
| grant1_id | output | IDW | Thread of the second grant |
| occupancy | output | N*CNT_W | Per-thread counts; thread i at bits [i*CNT_W +: CNT_W] |

## Verification
The properties assume that reset is asserted at the first clock edge. They also assume that every delta input is a known value in every cycle, so that the unchanged-count and ordering properties compare defined values. The stimulus holds reset through the opening cycles and drives every delta and eligibility bit from a fixed value or a bounded random draw on the falling edge. Deltas larger than the remaining headroom are drawn deliberately, so that both saturation bounds are reached without any input going undefined.

// File: rtl/icount_pkg.sv
package icount_pkg;

    localparam int unsigned DEF_THREADS = 8;
    localparam int unsigned DEF_CNT_W   = 6;
    localparam int unsigned DEF_DELTA_W = 3;

    typedef struct packed {
        logic [31:0] cur;
        logic [31:0] up;
        logic [31:0] down;
    } occ_step_t;

    function automatic int unsigned id_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Combined update: add first, then remove, then clamp both ends.
    function automatic logic [31:0] occ_next(input occ_step_t s, input logic [31:0] maxv);
        logic [31:0] total;
        logic [31:0] res;
        total = s.cur + s.up;
        if (s.down >= total) res = 32'd0;
        else                 res = total - s.down;
        if (res > maxv)      res = maxv;
        return res;
    endfunction

endpackage

// File: rtl/icount_counter.sv
module icount_counter #(
    parameter int unsigned CNT_W   = icount_pkg::DEF_CNT_W,
    parameter int unsigned DELTA_W = icount_pkg::DEF_DELTA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [DELTA_W-1:0] add_n,
    input  logic [DELTA_W-1:0] sub_issue,
    input  logic [DELTA_W-1:0] sub_flush,
    output logic [CNT_W-1:0]   count
);
    import icount_pkg::*;

    localparam logic [31:0] MAXV = 32'((64'd1 << CNT_W) - 64'd1);

    occ_step_t   step;
    logic [31:0] nxt;

    always_comb begin
        step.cur  = 32'(count);
        step.up   = 32'(add_n);
        step.down = 32'(sub_issue) + 32'(sub_flush);
        nxt       = occ_next(step, MAXV);
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= nxt[CNT_W-1:0];
    end
endmodule

// File: rtl/icount_pick.sv
module icount_pick #(
    parameter int unsigned N     = icount_pkg::DEF_THREADS,
    parameter int unsigned CNT_W = icount_pkg::DEF_CNT_W,
    parameter int unsigned IDW   = icount_pkg::id_width(N)
) (
    input  logic [N*CNT_W-1:0] counts,
    input  logic [N-1:0]       mask,
    output logic               valid,
    output logic [IDW-1:0]     id
);
    logic [CNT_W-1:0] best;

    // Strict less-than keeps the lowest index on equal counts.
    always_comb begin
        valid = 1'b0;
        id    = '0;
        best  = '0;
        for (int i = 0; i < int'(N); i++) begin
            if (mask[i] && (!valid || counts[i*CNT_W +: CNT_W] < best)) begin
                valid = 1'b1;
                id    = IDW'(i);
                best  = counts[i*CNT_W +: CNT_W];
            end
        end
    end
endmodule

// File: rtl/fetch_chooser.sv
module fetch_chooser #(
    parameter int unsigned N       = icount_pkg::DEF_THREADS,
    parameter int unsigned CNT_W   = icount_pkg::DEF_CNT_W,
    parameter int unsigned DELTA_W = icount_pkg::DEF_DELTA_W,
    localparam int unsigned IDW    = icount_pkg::id_width(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         eligible,
    input  logic [N*DELTA_W-1:0] fetch_n,
    input  logic [N*DELTA_W-1:0] issue_n,
    input  logic [N*DELTA_W-1:0] flush_n,
    output logic                 grant0_valid,
    output logic [IDW-1:0]       grant0_id,
    output logic                 grant1_valid,
    output logic [IDW-1:0]       grant1_id,
    output logic [N*CNT_W-1:0]   occupancy
);
    logic [N-1:0] second_mask;

    for (genvar t = 0; t < int'(N); t++) begin : g_thr
        icount_counter #(.CNT_W(CNT_W), .DELTA_W(DELTA_W)) u_cnt (
            .clk      (clk),
            .rst      (rst),
            .add_n    (fetch_n[t*DELTA_W +: DELTA_W]),
            .sub_issue(issue_n[t*DELTA_W +: DELTA_W]),
            .sub_flush(flush_n[t*DELTA_W +: DELTA_W]),
            .count    (occupancy[t*CNT_W +: CNT_W])
        );
    end

    icount_pick #(.N(N), .CNT_W(CNT_W), .IDW(IDW)) u_first (
        .counts(occupancy),
        .mask  (eligible),
        .valid (grant0_valid),
        .id    (grant0_id)
    );

    always_comb begin
        second_mask = eligible;
        if (grant0_valid) second_mask[grant0_id] = 1'b0;
    end

    icount_pick #(.N(N), .CNT_W(CNT_W), .IDW(IDW)) u_second (
        .counts(occupancy),
        .mask  (second_mask),
        .valid (grant1_valid),
        .id    (grant1_id)
    );
endmodule

// File: rtl/fetch_chooser_chk.sv
module fetch_chooser_chk #(
    parameter int unsigned N       = 8,
    parameter int unsigned CNT_W   = 6,
    parameter int unsigned DELTA_W = 3,
    parameter int unsigned IDW     = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic [N-1:0]         eligible,
    input logic [N*DELTA_W-1:0] fetch_n,
    input logic [N*DELTA_W-1:0] issue_n,
    input logic [N*DELTA_W-1:0] flush_n,
    input logic                 grant0_valid,
    input logic [IDW-1:0]       grant0_id,
    input logic                 grant1_valid,
    input logic [IDW-1:0]       grant1_id,
    input logic [N*CNT_W-1:0]   occupancy
);
    logic [CNT_W-1:0] c0, c1;
    assign c0 = occupancy[grant0_id*CNT_W +: CNT_W];
    assign c1 = occupancy[grant1_id*CNT_W +: CNT_W];

    // R1
    reset_clear_chk: assert property (@(posedge clk) rst |=> occupancy == '0);

    // R9
    distinct_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (grant0_valid && grant1_valid) |-> grant0_id != grant1_id);

    // R7
    first_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        grant0_valid |-> eligible[grant0_id]);

    // R7
    second_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        grant1_valid |-> (eligible[grant1_id] && grant0_valid));

    // R7
    none_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        (eligible == '0) |-> !grant0_valid);

    // R7
    single_eligible_chk: assert property (@(posedge clk) disable iff (rst)
        ($countones(eligible) == 1) |-> (grant0_valid && !grant1_valid));

    // R5
    order_chk: assert property (@(posedge clk) disable iff (rst)
        (grant0_valid && grant1_valid) |-> (c0 < c1 || (c0 == c1 && grant0_id < grant1_id)));

    for (genvar t = 0; t < int'(N); t++) begin : g_hold
        // R8
        idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (fetch_n[t*DELTA_W +: DELTA_W] == '0 && issue_n[t*DELTA_W +: DELTA_W] == '0 &&
             flush_n[t*DELTA_W +: DELTA_W] == '0)
            |=> occupancy[t*CNT_W +: CNT_W] == $past(occupancy[t*CNT_W +: CNT_W]));
    end
endmodule

bind fetch_chooser fetch_chooser_chk #(.N(N), .CNT_W(CNT_W), .DELTA_W(DELTA_W), .IDW(IDW)) u_chk (
    .clk(clk), .rst(rst), .eligible(eligible), .fetch_n(fetch_n), .issue_n(issue_n),
    .flush_n(flush_n), .grant0_valid(grant0_valid), .grant0_id(grant0_id),
    .grant1_valid(grant1_valid), .grant1_id(grant1_id), .occupancy(occupancy)
);

// File: tb/sim_fetch_chooser.sv
module sim_fetch_chooser;
    localparam int N = 8, CW = 4, DW = 3, IW = 3;
    localparam int MAXC = (1 << CW) - 1;

    logic clk = 1'b0, rst = 1'b1;
    logic [N-1:0]    el = '1;
    logic [N*DW-1:0] fn = '0, isn = '0, fln = '0;
    logic            g0v, g1v;
    logic [IW-1:0]   g0, g1;
    logic [N*CW-1:0] occ;

    int fin[N], iss[N], fls[N], model[N], tag[N];
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    fetch_chooser #(.N(N), .CNT_W(CW), .DELTA_W(DW)) u0 (
        .clk(clk), .rst(rst), .eligible(el), .fetch_n(fn), .issue_n(isn), .flush_n(fln),
        .grant0_valid(g0v), .grant0_id(g0), .grant1_valid(g1v), .grant1_id(g1), .occupancy(occ));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Pick the eligible thread with the smallest model count, skipping one index.
    function automatic int pick(input int skip);
        int b = -1;
        for (int i = 0; i < N; i++)
            if (el[i] && i != skip && (b < 0 || model[i] < model[b])) b = i;
        return b;
    endfunction

    task automatic check_all();
        int e0, e1, ne;
        for (int i = 0; i < N; i++) begin
            case (tag[i])
                1: chk("R1", int'(occ[i*CW +: CW]), model[i]);
                3: chk("R3", int'(occ[i*CW +: CW]), model[i]);
                4: chk("R4", int'(occ[i*CW +: CW]), model[i]);
                8: chk("R8", int'(occ[i*CW +: CW]), model[i]);
                default: chk("R2", int'(occ[i*CW +: CW]), model[i]);
            endcase
        end
        ne = $countones(el);
        e0 = pick(-1);
        e1 = (e0 < 0) ? -1 : pick(e0);
        if (ne < 2) begin
            chk("R7", int'(g0v), (ne >= 1) ? 1 : 0);
            chk("R7", int'(g1v), 0);
        end else begin
            chk("R5", g0v ? int'(g0) : -1, e0);
            chk("R6", g1v ? int'(g1) : -1, e1);
            if (g0v && g1v && g0 == g1) chk("R9", int'(g1), -1);
        end
        if (ne == 1) chk("R7", g0v ? int'(g0) : -1, e0);
    endtask

    task automatic cycle();
        int tot, dn, r;
        @(negedge clk);
        for (int i = 0; i < N; i++) begin
            fn[i*DW +: DW]  = DW'(fin[i]);
            isn[i*DW +: DW] = DW'(iss[i]);
            fln[i*DW +: DW] = DW'(fls[i]);
        end
        #2;
        if (!rst) check_all();
        @(posedge clk);
        #1;
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                model[i] = 0; tag[i] = 1;
            end else begin
                tot = model[i] + fin[i];
                dn  = iss[i] + fls[i];
                r   = (dn >= tot) ? 0 : tot - dn;
                if (fin[i] == 0 && dn == 0) tag[i] = 8;
                else if (dn > tot)          tag[i] = 3;
                else if (r > MAXC)          tag[i] = 4;
                else                        tag[i] = 2;
                if (r > MAXC) r = MAXC;
                model[i] = r;
            end
        end
    endtask

    task automatic set_all(input int f, input int s, input int x);
        for (int i = 0; i < N; i++) begin fin[i] = f; iss[i] = s; fls[i] = x; end
    endtask

    initial begin
        set_all(5, 1, 0);
        repeat (3) cycle();              // R1: reset ignores deltas
        rst = 1'b0;
        set_all(0, 0, 0);
        cycle();                          // R1 check of zero counts, tie -> ids 0,1
        for (int i = 0; i < N; i++) fin[i] = 7 - i;
        cycle();                          // R2 distinct counts
        set_all(0, 0, 0);
        cycle();                          // R5/R6 ordering on distinct counts
        set_all(7, 0, 0);
        repeat (4) cycle();               // R4 saturation high
        set_all(0, 0, 0);
        cycle();
        set_all(7, 7, 7);
        repeat (2) cycle();               // R2 simultaneous update
        set_all(0, 7, 7);
        repeat (2) cycle();               // R3 saturation low
        set_all(0, 0, 0);
        el = 8'b0010_0000; cycle();       // R7 single eligible
        el = 8'b0000_0000; cycle();       // R7 none eligible
        el = 8'b1000_0001; fin[7] = 2; cycle();
        fin[7] = 0; cycle();
        for (int n = 0; n < 3000; n++) begin
            el = N'($urandom);
            for (int i = 0; i < N; i++) begin
                fin[i] = $urandom % 8; iss[i] = $urandom % 8; fls[i] = ($urandom % 3 == 0) ? $urandom % 8 : 0;
                if ($urandom % 4 == 0) begin fin[i] = 0; iss[i] = 0; fls[i] = 0; end
            end
            cycle();
        end
        set_all(0, 0, 0);
        cycle();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule